// File: doc/BRIEF.md
# Acyclic Register Block Access Handler

This block serves acyclic read and write requests that a fieldbus front end delivers as a byte stream. Each request has a four-byte header: an operation code, a slot number, a block index and a byte count. A write request also carries data. The block index selects a window of 16-bit registers that starts at index × 10. The block answers with a byte stream of its own. That stream is a data response, which echoes the header and, for a read, appends the register contents. Otherwise it is an error response of four bytes that carries a diagnostic code.

Each register in the local file has attributes: whether it is implemented, whether it is writable, and its lowest and highest legal value. A write is all-or-nothing. A first pass checks every word of the buffered request against the attributes. Only when all words pass does a second pass store them, and any failure leaves the register file untouched. Both stream directions use valid/ready with a last flag. The block accepts no new request until the last byte of its response has been taken.

Top module: `acy_blk_access`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A good read (code 0x5E) returns the four header bytes unchanged, then the register words with the most significant byte first. The response is 4 + length bytes long, and `rsp_last` marks only its final byte.
- R3: The first register addressed is index × 10 and the request covers length/2 consecutive registers.
- R4: In each group of ten registers, offsets 8 and 9 are unimplemented and read back as 0x0000.
- R5: A good write (code 0x5F) stores every implemented register in the window and answers with the four header bytes echoed.
- R6: An error response is four bytes: the operation code OR 0x80 (0xDE or 0xDF), then 0x80, then 0xB6, then a diagnostic code. Code 7 is returned for each of: a slot other than 1; an odd length; a length below 2 or above 40; a frame shorter than 4 bytes; a read frame not exactly 4 bytes long; a write frame not exactly 4 + length bytes long.
- R7: A window that reaches past the last register (default 60 registers, addresses 0 to 59) returns code 7. A window ending exactly at address 59 is served.
- R8: A request whose first byte is neither 0x5E nor 0x5F gets no response, and the next request is served normally.
- R9: A write that covers any implemented read-only register (addresses 0 to 9) returns code 8, whatever the data.
- R10: A written word above the register's maximum returns code 10, and one below its minimum returns code 11. Addresses 20 to 29 have the maximum 0x00FF, and addresses 30 to 39 have the minimum 0x0010. Every other register accepts 0x0000 to 0xFFFF. A word equal to a limit is accepted.
- R11: A write that supplies a nonzero word for an unimplemented address returns code 3. A zero word there is accepted.
- R12: When a write fails, no register changes. The code reported is the one of the lowest failing address.
- R13: A request longer than 44 bytes returns code 255.
- R14: `req_ready` is low from the last request byte until the last response byte is accepted. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request byte valid |
| req_data | input | 8 | Request byte |
| req_last | input | 1 | Final byte of the request |
| req_ready | output | 1 | Block accepts a request byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |
| rsp_ready | input | 1 | Downstream accepts the response byte |

## Verification
The assertions assume that the response sink follows valid/ready rules and that a request always ends with `req_last`. They do not assume the request is well formed, so the bench deliberately sends truncated, padded, overlong and unknown-code frames. The stimulus only raises `req_valid` between whole-byte handshakes and never changes a byte before it is taken. It applies backpressure on the response side in irregular patterns, so the hold and no-overlap properties are exercised during real stalls.

// File: rtl/acy_pkg.sv
package acy_pkg;
  localparam logic [7:0] FN_READ     = 8'h5E;
  localparam logic [7:0] FN_WRITE    = 8'h5F;
  localparam logic [7:0] SLOT_ONE    = 8'h01;
  localparam logic [7:0] ERR_FN_MASK = 8'h80;
  localparam logic [7:0] ERR_B1      = 8'h80;
  localparam logic [7:0] ERR_B2      = 8'hB6;

  localparam logic [7:0] EC_UNMANAGED = 8'd3;
  localparam logic [7:0] EC_NOT_FOUND = 8'd7;
  localparam logic [7:0] EC_READ_ONLY = 8'd8;
  localparam logic [7:0] EC_TOO_HIGH  = 8'd10;
  localparam logic [7:0] EC_TOO_LOW   = 8'd11;
  localparam logic [7:0] EC_INTERNAL  = 8'd255;

  localparam int HDR_BYTES  = 4;
  localparam int BLOCK_STEP = 10;

  typedef enum logic [2:0] {
    ST_RX, ST_CHECK, ST_VALIDATE, ST_COMMIT, ST_FILL, ST_SEND
  } acy_state_e;
endpackage

// File: rtl/acy_attr_map.sv
module acy_attr_map #(
  parameter int AW             = 6,
  parameter int DEPTH          = 60,
  parameter int GROUP          = 10,
  parameter int LIVE_PER_GROUP = 8,
  parameter int RO_BELOW       = 10,
  parameter int CAP_FIRST      = 20,
  parameter int CAP_LAST       = 29,
  parameter logic [15:0] CAP_VALUE = 16'h00FF,
  parameter int FLOOR_FIRST    = 30,
  parameter int FLOOR_LAST     = 39,
  parameter logic [15:0] FLOOR_VALUE = 16'h0010
) (
  input  logic [AW-1:0] addr,
  output logic          live,
  output logic          writable,
  output logic [15:0]   lo_lim,
  output logic [15:0]   hi_lim
);
  always_comb begin
    int a;
    a        = int'(addr);
    live     = (a < DEPTH) && ((a % GROUP) < LIVE_PER_GROUP);
    writable = live && (a >= RO_BELOW);
    hi_lim   = (a >= CAP_FIRST && a <= CAP_LAST) ? CAP_VALUE : 16'hFFFF;
    lo_lim   = (a >= FLOOR_FIRST && a <= FLOOR_LAST) ? FLOOR_VALUE : 16'h0000;
  end
endmodule

// File: rtl/acy_regfile.sv
module acy_regfile #(
  parameter int AW    = 6,
  parameter int DEPTH = 60,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R7: the window check keeps every store inside the file
  p_write_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/acy_tx_stream.sv
module acy_tx_stream #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic [7:0]    byte_in,
  output logic [LW-1:0] idx,
  output logic          m_valid,
  output logic [7:0]    m_data,
  output logic          m_last,
  input  logic          m_ready,
  output logic          done
);
  logic active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active && (!m_valid || m_ready)) begin
        if (idx < len) begin
          m_valid <= 1'b1;
          m_data  <= byte_in;
          m_last  <= (idx == len - 1'b1);
          idx     <= idx + 1'b1;
        end else begin
          m_valid <= 1'b0;
          m_last  <= 1'b0;
          active  <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  // R14: a stalled byte is held
  p_hold_r14: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
  // R2: the end marker only travels with a valid byte
  p_last_valid_r2: assert property (@(posedge clk) disable iff (rst)
    m_last |-> m_valid);
endmodule

// File: rtl/acy_blk_access.sv
module acy_blk_access
  import acy_pkg::*;
#(
  parameter int REG_DEPTH = 60,
  parameter int MAX_WORDS = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [7:0] req_data,
  input  logic       req_last,
  output logic       req_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rsp_last,
  input  logic       rsp_ready
);
  localparam int AW        = $clog2(REG_DEPTH);
  localparam int BUF_BYTES = HDR_BYTES + 2 * MAX_WORDS;
  localparam int CW        = $clog2(BUF_BYTES + 1);
  localparam int PW        = $clog2(MAX_WORDS + 1);
  localparam int MAX_LEN   = 2 * MAX_WORDS;

  acy_state_e     st;
  logic [7:0]     fbuf [BUF_BYTES];
  logic [CW-1:0]  rx_cnt;
  logic           rx_ovf;
  logic [PW-1:0]  ptr, nwords;
  logic [AW-1:0]  base, cur_addr, chk_base, rf_raddr;
  logic [CW-1:0]  tx_len, tx_idx, v_idx, fill_idx;
  logic           tx_go, tx_done, rd_live_q;
  logic [7:0]     tx_byte;
  logic           chk_drop, chk_err, v_fail;
  logic [7:0]     chk_code, v_code;
  logic [15:0]    cur_word, rf_rdata, a_lo, a_hi;
  logic           a_live, a_wr, rf_we;

  assign req_ready = (st == ST_RX);
  assign cur_addr  = base + AW'(ptr);

  // header screening once the whole request is buffered
  always_comb begin
    int len_i, cnt_i, first_i, need_i;
    len_i    = int'(fbuf[3]);
    cnt_i    = int'(rx_cnt);
    first_i  = int'(fbuf[2]) * BLOCK_STEP;
    need_i   = (fbuf[0] == FN_WRITE) ? HDR_BYTES + len_i : HDR_BYTES;
    chk_drop = (fbuf[0] != FN_READ) && (fbuf[0] != FN_WRITE);
    chk_base = AW'(first_i);
    chk_err  = 1'b1;
    chk_code = EC_NOT_FOUND;
    if (rx_ovf)
      chk_code = EC_INTERNAL;
    else if (cnt_i < HDR_BYTES || fbuf[1] != SLOT_ONE || (len_i % 2) != 0 ||
             len_i < 2 || len_i > MAX_LEN)
      chk_code = EC_NOT_FOUND;
    else if (first_i + len_i / 2 > REG_DEPTH)
      chk_code = EC_NOT_FOUND;
    else if (cnt_i != need_i)
      chk_code = EC_NOT_FOUND;
    else
      chk_err = 1'b0;
  end

  // per-word check against the attribute map
  always_comb begin
    logic [CW-1:0] raw;
    raw      = CW'(HDR_BYTES) + CW'({ptr, 1'b0});
    v_idx    = (int'(raw) < BUF_BYTES - 1) ? raw : '0;
    fill_idx = CW'(HDR_BYTES) + CW'({ptr - 1'b1, 1'b0});
    if (int'(fill_idx) >= BUF_BYTES - 1) fill_idx = '0;
    cur_word = {fbuf[v_idx], fbuf[v_idx + 1'b1]};
    v_fail   = 1'b1;
    v_code   = EC_UNMANAGED;
    if (!a_live)               v_fail = (cur_word != 16'h0000);
    else if (!a_wr)            v_code = EC_READ_ONLY;
    else if (cur_word > a_hi)  v_code = EC_TOO_HIGH;
    else if (cur_word < a_lo)  v_code = EC_TOO_LOW;
    else                       v_fail = 1'b0;
  end

  assign rf_we    = (st == ST_COMMIT) && a_live;
  assign rf_raddr = (st == ST_FILL && ptr != nwords) ? cur_addr : '0;
  assign tx_byte  = (int'(tx_idx) < BUF_BYTES) ? fbuf[tx_idx] : 8'h00;

  acy_attr_map #(.AW(AW), .DEPTH(REG_DEPTH)) u_attr (
    .addr(cur_addr), .live(a_live), .writable(a_wr), .lo_lim(a_lo), .hi_lim(a_hi)
  );

  acy_regfile #(.AW(AW), .DEPTH(REG_DEPTH), .DW(16)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(cur_addr), .wdata(cur_word),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  acy_tx_stream #(.LW(CW)) u_tx (
    .clk(clk), .rst(rst), .start(tx_go), .len(tx_len), .byte_in(tx_byte),
    .idx(tx_idx), .m_valid(rsp_valid), .m_data(rsp_data), .m_last(rsp_last),
    .m_ready(rsp_ready), .done(tx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RX;
      rx_cnt    <= '0;
      rx_ovf    <= 1'b0;
      ptr       <= '0;
      nwords    <= '0;
      base      <= '0;
      tx_len    <= '0;
      tx_go     <= 1'b0;
      rd_live_q <= 1'b0;
    end else begin
      tx_go <= 1'b0;
      unique case (st)
        ST_RX: if (req_valid) begin
          if (int'(rx_cnt) < BUF_BYTES) begin
            fbuf[rx_cnt] <= req_data;
            rx_cnt       <= rx_cnt + 1'b1;
          end else begin
            rx_ovf <= 1'b1;
          end
          if (req_last) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (chk_drop) begin
            st     <= ST_RX;
            rx_cnt <= '0;
            rx_ovf <= 1'b0;
          end else if (chk_err) begin
            fbuf[0] <= fbuf[0] | ERR_FN_MASK;
            fbuf[1] <= ERR_B1;
            fbuf[2] <= ERR_B2;
            fbuf[3] <= chk_code;
            tx_len  <= CW'(HDR_BYTES);
            tx_go   <= 1'b1;
            st      <= ST_SEND;
          end else begin
            base   <= chk_base;
            nwords <= PW'(fbuf[3] >> 1);
            ptr    <= '0;
            st     <= (fbuf[0] == FN_WRITE) ? ST_VALIDATE : ST_FILL;
          end
        end
        ST_VALIDATE: begin
          if (v_fail) begin
            fbuf[0] <= fbuf[0] | ERR_FN_MASK;
            fbuf[1] <= ERR_B1;
            fbuf[2] <= ERR_B2;
            fbuf[3] <= v_code;
            tx_len  <= CW'(HDR_BYTES);
            tx_go   <= 1'b1;
            st      <= ST_SEND;
          end else if (ptr == nwords - 1'b1) begin
            ptr <= '0;
            st  <= ST_COMMIT;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        ST_COMMIT: begin
          if (ptr == nwords - 1'b1) begin
            tx_len <= CW'(HDR_BYTES);
            tx_go  <= 1'b1;
            st     <= ST_SEND;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        ST_FILL: begin
          rd_live_q <= a_live;
          if (ptr != '0) begin
            fbuf[fill_idx]        <= rd_live_q ? rf_rdata[15:8] : 8'h00;
            fbuf[fill_idx + 1'b1] <= rd_live_q ? rf_rdata[7:0]  : 8'h00;
          end
          if (ptr == nwords) begin
            tx_len <= CW'(HDR_BYTES) + CW'({nwords, 1'b0});
            tx_go  <= 1'b1;
            st     <= ST_SEND;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        ST_SEND: if (tx_done) begin
          st     <= ST_RX;
          rx_cnt <= '0;
          rx_ovf <= 1'b0;
        end
        default: st <= ST_RX;
      endcase
    end
  end

  // R14: no response byte is offered while a request is being taken
  p_no_overlap_r14: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && rsp_valid));
  // R12: the store pass is entered only from a finished check pass
  p_commit_entry_r12: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COMMIT && $past(st) != ST_COMMIT) |-> ($past(st) == ST_VALIDATE));
  // R9: a store never lands on a read-only or unimplemented register
  p_store_legal_r9: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> a_wr);
endmodule

// File: tb/sim_acy_blk_access.sv
module sim_acy_blk_access;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_last = 1'b0, rsp_ready = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic req_ready, rsp_valid, rsp_last;
  logic [7:0] rsp_data;

  always #5 clk = ~clk;

  acy_blk_access u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data),
    .req_last(req_last), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_ready(rsp_ready)
  );

  int errors = 0, checks = 0;
  int hold_viol = 0, ovl_viol = 0;
  logic [7:0]  fr [64];
  logic [7:0]  rsp [64];
  logic [7:0]  ex [64];
  logic [15:0] shadow [60];
  int rn, en, fn_len;
  bit done_flag = 0;

  // {code, slot, index, length, mode, fill, expect}; expect 0x100 = served, 0x200 = silent
  localparam logic [63:0] TBL [25] = '{
    {8'h5E, 8'h01, 8'd0, 8'd40, 4'd0, 16'h0000, 12'h100},
    {8'h5F, 8'h01, 8'd1, 8'd20, 4'd0, 16'h1234, 12'h100},
    {8'h5E, 8'h01, 8'd1, 8'd20, 4'd0, 16'h0000, 12'h100},
    {8'h5F, 8'h01, 8'd2, 8'd20, 4'd0, 16'h00F8, 12'h100},
    {8'h5F, 8'h01, 8'd2, 8'd20, 4'd0, 16'h00F9, 12'h00A},
    {8'h5E, 8'h01, 8'd2, 8'd16, 4'd0, 16'h0000, 12'h100},
    {8'h5F, 8'h01, 8'd3, 8'd4,  4'd0, 16'h000F, 12'h00B},
    {8'h5F, 8'h01, 8'd3, 8'd4,  4'd0, 16'h0010, 12'h100},
    {8'h5F, 8'h01, 8'd0, 8'd2,  4'd0, 16'h0001, 12'h008},
    {8'h5F, 8'h01, 8'd0, 8'd20, 4'd0, 16'h0000, 12'h008},
    {8'h5F, 8'h01, 8'd1, 8'd20, 4'd1, 16'h0500, 12'h003},
    {8'h5E, 8'h01, 8'd1, 8'd20, 4'd0, 16'h0000, 12'h100},
    {8'h5E, 8'h02, 8'd0, 8'd2,  4'd0, 16'h0000, 12'h007},
    {8'h5E, 8'h01, 8'd0, 8'd3,  4'd0, 16'h0000, 12'h007},
    {8'h5E, 8'h01, 8'd0, 8'd42, 4'd0, 16'h0000, 12'h007},
    {8'h5E, 8'h01, 8'd0, 8'd0,  4'd0, 16'h0000, 12'h007},
    {8'h5E, 8'h01, 8'd5, 8'd40, 4'd0, 16'h0000, 12'h007},
    {8'h5E, 8'h01, 8'd6, 8'd2,  4'd0, 16'h0000, 12'h007},
    {8'h5F, 8'h01, 8'd5, 8'd40, 4'd0, 16'h0000, 12'h007},
    {8'h5A, 8'h01, 8'd0, 8'd2,  4'd0, 16'h0000, 12'h200},
    {8'h5E, 8'h01, 8'd5, 8'd20, 4'd0, 16'h0000, 12'h100},
    {8'h5F, 8'h01, 8'd3, 8'd20, 4'd0, 16'h0020, 12'h100},
    {8'h5E, 8'h01, 8'd3, 8'd20, 4'd0, 16'h0000, 12'h100},
    {8'h5F, 8'h01, 8'd2, 8'd2,  4'd0, 16'h00FF, 12'h100},
    {8'h5E, 8'h01, 8'd1, 8'd2,  4'd0, 16'h0000, 12'h100}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2 R4 full read";
      1: return "R5 write";
      2: return "R3 R4 read back";
      3: return "R10 at maximum";
      4: return "R10 above maximum";
      5: return "R12 unchanged after fail";
      6: return "R10 below minimum";
      7: return "R10 at minimum";
      8: return "R9 read-only";
      9: return "R9 read-only zero data";
      10: return "R11 nonzero unimplemented";
      11: return "R12 unchanged after code 3";
      12: return "R6 bad slot";
      13: return "R6 odd length";
      14: return "R6 length 42";
      15: return "R6 length 0";
      16: return "R7 window past end";
      17: return "R7 index past end";
      18: return "R7 write past end";
      19: return "R8 unknown code";
      20: return "R7 last window";
      21: return "R11 zero unimplemented";
      22: return "R11 read back";
      23: return "R10 single word";
      24: return "R2 single word";
      default: return "R2";
    endcase
  endfunction

  task automatic build(input logic [7:0] fn, input logic [7:0] sl, input logic [7:0] ix,
                       input logic [7:0] ln, input int mode, input logic [15:0] fill);
    fr[0] = fn; fr[1] = sl; fr[2] = ix; fr[3] = ln;
    fn_len = 4;
    if (fn == 8'h5F) begin
      for (int p = 0; p < int'(ln) / 2; p++) begin
        int a;
        logic [15:0] w;
        a = int'(ix) * 10 + p;
        w = ((a % 10) >= 8 && mode == 0) ? 16'h0000 : fill + 16'(p);
        fr[4 + 2 * p] = w[15:8];
        fr[5 + 2 * p] = w[7:0];
      end
      fn_len = 4 + int'(ln);
    end
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_data = fr[i]; req_last = (i == n - 1);
      while (!req_ready) @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0; req_last = 1'b0;
  endtask

  task automatic collect(input int limit, input bit stall);
    bit got_last, pend;
    logic [7:0] pdata;
    logic plast;
    got_last = 0; pend = 0; pdata = 0; plast = 0; rn = 0;
    for (int c = 0; c < limit && !got_last; c++) begin
      @(negedge clk);
      if (pend && (!rsp_valid || rsp_data != pdata || rsp_last != plast)) hold_viol++;
      if (rsp_valid && req_ready) ovl_viol++;
      rsp_ready = stall ? ((c % 5) < 2) : ((c % 3) != 2);
      pend = rsp_valid && !rsp_ready; pdata = rsp_data; plast = rsp_last;
      if (rsp_valid && rsp_ready) begin
        if (rn < 64) rsp[rn] = rsp_data;
        rn++;
        if (rsp_last) got_last = 1;
      end
    end
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic expect_err(input logic [7:0] fn, input logic [7:0] code);
    ex[0] = fn | 8'h80; ex[1] = 8'h80; ex[2] = 8'hB6; ex[3] = code; en = 4;
  endtask

  task automatic compare(input string tag);
    int bad;
    bad = -1;
    checks++;
    if (rn != en) begin
      errors++;
      $display("FAIL %s: response length %0d, expected %0d", tag, rn, en);
    end else begin
      for (int i = 0; i < en; i++) if (bad < 0 && rsp[i] != ex[i]) bad = i;
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s: byte %0d is %h, expected %h", tag, bad, rsp[bad], ex[bad]);
      end
    end
  endtask

  task automatic run_entry(input int i);
    logic [63:0] e;
    logic [7:0] fn, sl, ix, ln;
    logic [11:0] xp;
    e = TBL[i];
    fn = e[63:56]; sl = e[55:48]; ix = e[47:40]; ln = e[39:32]; xp = e[11:0];
    build(fn, sl, ix, ln, int'(e[31:28]), e[27:12]);
    push(fn_len);
    collect((xp == 12'h200) ? 60 : 600, 1'b0);
    if (xp == 12'h200) begin
      en = 0;
    end else if (xp == 12'h100) begin
      ex[0] = fn; ex[1] = sl; ex[2] = ix; ex[3] = ln; en = 4;
      for (int p = 0; p < int'(ln) / 2; p++) begin
        int a;
        a = int'(ix) * 10 + p;
        if (fn == 8'h5E) begin
          ex[4 + 2 * p] = shadow[a][15:8];
          ex[5 + 2 * p] = shadow[a][7:0];
        end else begin
          shadow[a] = {fr[4 + 2 * p], fr[5 + 2 * p]};
        end
      end
      if (fn == 8'h5E) en = 4 + int'(ln);
    end else begin
      expect_err(fn, xp[7:0]);
    end
    compare(tag_of(i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 60; a++) shadow[a] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    checks++;
    if (req_ready !== 1'b1) begin
      errors++; $display("FAIL R1: req_ready %b, expected 1", req_ready);
    end
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R1: rsp_valid %b, expected 0", rsp_valid);
    end

    for (int i = 0; i < 25; i++) run_entry(i);

    // R6: frame shorter than the header
    fr[0] = 8'h5E; fr[1] = 8'h01;
    push(2); collect(600, 1'b0); expect_err(8'h5E, 8'd7); compare("R6 short frame");

    // R6: write carrying fewer data bytes than its length
    build(8'h5F, 8'h01, 8'd1, 8'd4, 0, 16'h0001);
    push(6); collect(600, 1'b0); expect_err(8'h5F, 8'd7); compare("R6 write count mismatch");

    // R6: read carrying trailing bytes
    build(8'h5E, 8'h01, 8'd0, 8'd2, 0, 16'h0000);
    fr[4] = 8'h00;
    push(5); collect(600, 1'b0); expect_err(8'h5E, 8'd7); compare("R6 read with trailer");

    // R13: request overflowing the 44-byte buffer
    build(8'h5F, 8'h01, 8'd1, 8'd40, 0, 16'h0100);
    for (int k = 44; k < 50; k++) fr[k] = 8'h00;
    push(50); collect(600, 1'b0); expect_err(8'h5F, 8'hFF); compare("R13 overflow");

    // R12: nothing from the rejected writes reached block 1
    build(8'h5E, 8'h01, 8'd1, 8'd20, 0, 16'h0000);
    push(4); collect(600, 1'b0);
    ex[0] = 8'h5E; ex[1] = 8'h01; ex[2] = 8'd1; ex[3] = 8'd20; en = 24;
    for (int p = 0; p < 10; p++) begin
      ex[4 + 2 * p] = shadow[10 + p][15:8];
      ex[5 + 2 * p] = shadow[10 + p][7:0];
    end
    compare("R12 block 1 intact");

    // R14: heavy backpressure on a full-length read
    hold_viol = 0; ovl_viol = 0;
    build(8'h5E, 8'h01, 8'd1, 8'd40, 0, 16'h0000);
    push(4); collect(2000, 1'b1);
    ex[0] = 8'h5E; ex[1] = 8'h01; ex[2] = 8'd1; ex[3] = 8'd40; en = 44;
    for (int p = 0; p < 20; p++) begin
      ex[4 + 2 * p] = shadow[10 + p][15:8];
      ex[5 + 2 * p] = shadow[10 + p][7:0];
    end
    compare("R14 stalled read");
    checks++;
    if (hold_viol != 0) begin
      errors++; $display("FAIL R14: %0d hold violations, expected 0", hold_viol);
    end
    checks++;
    if (ovl_viol != 0) begin
      errors++; $display("FAIL R14: %0d overlap cycles, expected 0", ovl_viol);
    end

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule